// File: doc/BRIEF.md
# Display interrupt status controller

This block gathers single-cycle event pulses coming from the raster engine and the frame DMA of a display pipeline. It latches them in a raw status register and qualifies them with an enable mask. From the result it drives one level-sensitive interrupt line. Software reaches the block through a plain register port: an address, a write strobe with write data, and combinational read data.

Software services an interrupt in a fixed order. It reads the masked view and writes ones back to that view to acknowledge the events it has handled. It then writes the end-of-interrupt register. A small arming state machine sits behind the line. Once the line has asserted and the pending set has drained, the line stays low until the end-of-interrupt write, even if fresh events arrive in the meantime.

The arming machine has three states:
- `ST_ARMED` waits for pending work. It moves to `ST_ACTIVE` when the masked status is non-zero.
- `ST_ACTIVE` drives the line high. While anything is still pending it stays put. Once nothing is pending, it goes to `ST_WAIT_EOI`, or straight back to `ST_ARMED` if the end-of-interrupt write lands in that same cycle.
- `ST_WAIT_EOI` holds the line low until the end-of-interrupt write. It then goes to `ST_ACTIVE` if work is pending, and to `ST_ARMED` otherwise.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset the raw status and the enable mask read 0 and the interrupt line is low.
- R2: A one on an implemented event input sets the matching raw status bit at the next clock edge. The bit then holds until software clears it. Bit positions: 0 frame complete, 1 raster complete, 2 sync loss, 3 bias-toggle count, 5 FIFO underflow, 6 palette loaded, 8 end of buffer 0, 9 end of buffer 1.
- R3: The read map is as follows:
  - Address 0x00 returns the raw status.
  - Address 0x04 returns the raw status ANDed with the enable mask.
  - Address 0x10 and unmapped addresses return 0.
  - An event on a disabled bit appears at 0x00 but not at 0x04.
- R4: Writing ones to address 0x04 clears those status bits, and zero bits leave status unchanged. Writes to address 0x00 have no effect.
- R5: If an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: Writing ones to address 0x08 sets those enable bits. Writing ones to address 0x0C clears them. Both addresses read back the current enable mask.
- R7: Bits 4, 7 and 10 and above of status and enable always read 0, whatever is written or pulsed.
- R8: From `ST_ARMED`, an enabled event sampled at clock edge k raises the line after clock edge k+1.
- R9: The line stays high while masked status is non-zero. It falls one edge after the masked status empties, and does not rise again before an end-of-interrupt write.
- R10: A write of any value to address 0x10 re-arms the line. If masked status is non-zero at that write, the line is high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| evt_i | input | EVT_W | Event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt line |

## Verification
The assertions assume the following about the inputs once reset is released:
- Every input is a known value.
- A write happens only in a cycle where `wr_en_i` is high.
- The clearing-write property considers only cycles with no simultaneous event, since R5 lets an event override the clear.

The stimulus keeps to these assumptions in three ways. All inputs are driven from time zero at the falling edge. Events are mixed freely with writes to every mapped and unmapped address. The one overlap of event and clear that the bench aims for is a directed case checked against the R5 rule.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    localparam int EVT_W = 10;

    localparam int OFS_RAW = 'h00;
    localparam int OFS_MSK = 'h04;
    localparam int OFS_ENS = 'h08;
    localparam int OFS_ENC = 'h0C;
    localparam int OFS_EOI = 'h10;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_ACTIVE   = 2'd1,
        ST_WAIT_EOI = 2'd2
    } arm_state_e;

    // Implemented status bits: all except positions 4 and 7.
    function automatic logic [EVT_W-1:0] impl_mask();
        logic [EVT_W-1:0] m;
        for (int i = 0; i < EVT_W; i++) begin
            m[i] = (i != 4) && (i != 7);
        end
        return m;
    endfunction

endpackage

// File: rtl/disp_irq_status.sv
module disp_irq_status
    import disp_irq_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] stat_q;

    // Set dominates clear on the same bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_i) | set_i;
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/disp_irq_enable.sv
module disp_irq_enable
    import disp_irq_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] en_o
);

    logic [W-1:0] en_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q | set_i) & ~clr_i;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/disp_irq_arm_fsm.sv
module disp_irq_arm_fsm
    import disp_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pending_i,
    input  logic       eoi_i,
    output logic       irq_o,
    output arm_state_e state_o
);

    arm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (pending_i) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!pending_i) state_d = eoi_i ? ST_ARMED : ST_WAIT_EOI;
            end
            ST_WAIT_EOI: begin
                if (eoi_i) state_d = pending_i ? ST_ACTIVE : ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            ST_ACTIVE: irq_o = 1'b1;
            default:   irq_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
    import disp_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MSK);
    localparam logic [ADDR_W-1:0] A_ENS = ADDR_W'(OFS_ENS);
    localparam logic [ADDR_W-1:0] A_ENC = ADDR_W'(OFS_ENC);
    localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFS_EOI);
    localparam logic [EVT_W-1:0]  IMPL  = impl_mask();

    logic [EVT_W-1:0] wbits, stat_w, en_w, masked_w;
    logic [EVT_W-1:0] st_clr, en_set, en_clr;
    logic             eoi_wr;
    logic             wdata_unused;
    arm_state_e       state_w;

    assign wbits        = wdata_i[EVT_W-1:0] & IMPL;
    assign wdata_unused = ^wdata_i[DATA_W-1:EVT_W];

    assign st_clr = (wr_en_i && addr_i == A_MSK) ? wbits : '0;
    assign en_set = (wr_en_i && addr_i == A_ENS) ? wbits : '0;
    assign en_clr = (wr_en_i && addr_i == A_ENC) ? wbits : '0;
    assign eoi_wr = wr_en_i && addr_i == A_EOI;

    disp_irq_status #(.W(EVT_W)) status_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (evt_i & IMPL),
        .clr_i (st_clr),
        .stat_o(stat_w)
    );

    disp_irq_enable #(.W(EVT_W)) enable_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (en_w)
    );

    assign masked_w = stat_w & en_w;

    disp_irq_arm_fsm arm_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pending_i(|masked_w),
        .eoi_i    (eoi_wr),
        .irq_o    (irq_o),
        .state_o  (state_w)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_RAW) begin
            rdata_o = DATA_W'(stat_w);
        end else if (addr_i == A_MSK) begin
            rdata_o = DATA_W'(masked_w);
        end else if (addr_i == A_ENS || addr_i == A_ENC) begin
            rdata_o = DATA_W'(en_w);
        end
    end

endmodule

// File: rtl/disp_irq_ctrl_chk.sv
module disp_irq_ctrl_chk
    import disp_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [EVT_W-1:0]  evt_i,
    input logic              irq_o,
    input logic [EVT_W-1:0]  stat,
    input logic [EVT_W-1:0]  en,
    input arm_state_e        state
);

    localparam logic [EVT_W-1:0] IMPL = impl_mask();

    logic pend, eoi, clr_wr, ens_wr;
    assign pend   = |(stat & en);
    assign eoi    = wr_en_i && addr_i == ADDR_W'(OFS_EOI);
    assign clr_wr = wr_en_i && addr_i == ADDR_W'(OFS_MSK);
    assign ens_wr = wr_en_i && addr_i == ADDR_W'(OFS_ENS);

    a_r5_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(evt_i & IMPL)) |=> ((stat & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

    a_r7_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat & ~IMPL) == '0) && ((en & ~IMPL) == '0));

    a_r4_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr && evt_i == '0) |=> ((stat & $past(wdata_i[EVT_W-1:0])) == '0));

    a_r6_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ens_wr |=> ((en & $past(wdata_i[EVT_W-1:0] & IMPL)) == $past(wdata_i[EVT_W-1:0] & IMPL)));

    a_r8_rise_when_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_ARMED && pend) |=> irq_o);

    a_r9_hold_until_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_WAIT_EOI && !eoi) |=> !irq_o);

    a_r9_rise_needs_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(pend));

    a_r10_eoi_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_WAIT_EOI && eoi && pend) |=> irq_o);

endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .evt_i  (evt_i),
    .irq_o  (irq_o),
    .stat   (stat_w),
    .en     (en_w),
    .state  (state_w)
);

// File: tb/disp_irq_ctrl_tb_top.sv
module disp_irq_ctrl_tb_top;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam int EW = 10;
    localparam logic [EW-1:0] IMPL = 10'h36F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [EW-1:0] evt = '0;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [EW-1:0] m_stat = '0;
    logic [EW-1:0] m_en   = '0;
    int            m_st   = 0;

    always #2 clk = ~clk;

    disp_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .addr_i (addr),
        .wr_en_i(wr_en),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .evt_i  (evt),
        .irq_o  (irq)
    );

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        case (a)
            5'h00:        return DW'(m_stat);
            5'h04:        return DW'(m_stat & m_en);
            5'h08, 5'h0C: return DW'(m_en);
            default:      return '0;
        endcase
    endfunction

    task automatic model_update(input logic [AW-1:0] a, input logic w,
                                input logic [DW-1:0] d, input logic [EW-1:0] e);
        logic          pend;
        logic          eoi;
        logic [EW-1:0] b;
        pend = |(m_stat & m_en);
        eoi  = w && a == 5'h10;
        b    = d[EW-1:0] & IMPL;
        case (m_st)
            0: if (pend) m_st = 1;
            1: if (!pend) m_st = eoi ? 0 : 2;
            default: if (eoi) m_st = pend ? 1 : 0;
        endcase
        m_stat = (m_stat & ~((w && a == 5'h04) ? b : '0)) | (e & IMPL);
        if (w && a == 5'h08) m_en = m_en | b;
        if (w && a == 5'h0C) m_en = m_en & ~b;
    endtask

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [AW-1:0] a, input logic w,
                        input logic [DW-1:0] d, input logic [EW-1:0] e);
        @(negedge clk);
        addr = a; wr_en = w; wdata = d; evt = e;
        #1;
        check(rdata, model_read(a), "R3 read view vs model");
        check(DW'(irq), DW'(m_st == 1), "R9 line vs model");
        @(posedge clk);
        model_update(a, w, d, e);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                      input logic exp_irq, input string tag);
        @(negedge clk);
        addr = a; wr_en = 1'b0; wdata = '0; evt = '0;
        #1;
        check(rdata, exp, tag);
        check(DW'(irq), DW'(exp_irq), tag);
        @(posedge clk);
        model_update(a, 1'b0, '0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(5'h00, 0, 0, "R1 raw after reset");
        rd(5'h08, 0, 0, "R1 enable after reset");

        step(5'h08, 1, 32'hFFFF_FFFF, 0);
        rd(5'h0C, 32'h36F, 0, "R6/R7 enable mask readback");

        step(5'h00, 0, 0, 10'h001);
        rd(5'h00, 32'h1, 0, "R2 frame event latched");
        rd(5'h04, 32'h1, 1, "R8 line raised");

        step(5'h04, 1, 0, 0);
        rd(5'h00, 32'h1, 1, "R4 zero write keeps bit");
        step(5'h00, 1, 32'hFFFF_FFFF, 0);
        rd(5'h00, 32'h1, 1, "R4 raw write ignored");

        step(5'h04, 1, 32'h1, 0);
        rd(5'h00, 0, 1, "R9 line held one edge");
        rd(5'h00, 0, 0, "R9 line fell");

        step(5'h00, 0, 0, 10'h002);
        rd(5'h00, 32'h2, 0, "R9 no rise before EOI");
        rd(5'h00, 32'h2, 0, "R9 still low");

        step(5'h10, 1, 32'h1234, 0);
        rd(5'h04, 32'h2, 1, "R10 EOI rearms");

        step(5'h04, 1, 32'h100, 10'h100);
        rd(5'h00, 32'h102, 1, "R5 event beats clear");

        step(5'h00, 0, 0, 10'h090);
        rd(5'h00, 32'h102, 1, "R7 unused events dropped");

        step(5'h04, 1, 32'hFFFF_FFFF, 0);
        step(5'h10, 1, 0, 0);
        rd(5'h08, 32'h36F, 0, "R6 set address reads mask");
        step(5'h0C, 1, 32'h1, 0);
        rd(5'h08, 32'h36E, 0, "R6 clear removes bit");
        rd(5'h14, 0, 0, "R3 unmapped reads zero");

        step(5'h00, 0, 0, 10'h001);
        rd(5'h04, 0, 0, "R3 disabled not in masked view");
        rd(5'h00, 32'h1, 0, "R3 disabled in raw view");

        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [EW-1:0] e;
            a = AW'(($urandom % 8) * 4);
            d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            e = ($urandom % 3 == 0) ? EW'($urandom) : '0;
            step(a, 1'($urandom % 2), d, e);
        end

        finish_run();
    end

endmodule